// File: doc/BRIEF.md
# Serial Register-Write Command Decoder

This block is the serial slave front end of a four-channel converter. A host frames a command by pulling chip select low and clocking bits in MSB first on the rising serial clock. When chip select returns high, the block judges the frame. It checks the bit count and, if enabled, the trailing check byte. It then compares the two device-address bits with the strap pins. A frame that passes updates the per-channel registers: the 12-bit output code, gain, offset and clear code. Broadcast codes update gain or offset on every channel at once. A control write is handed off as a single-cycle strobe with its 16-bit payload.

The serial pins are sampled in the system clock domain. The serial clock and chip select must therefore be slow against `clk_i`. A frame with bit 23 set is a read request. It changes no register, but it arms a readback. During the following frame, the selected register is presented on `miso_o` MSB first.

Top module: `spi_cmd_decoder`

## Requirements
- R1: With checking off, a frame is acted on only if exactly 24 serial clocks arrive while chip select is low. Fields: bit 23 is read (1) or write (0); bits 22:21 are the device address; bits 20:18 are the register select; bits 17:16 are the channel (00..11); bits 15:0 are the payload. Any other count leaves every register unchanged.
- R2: A frame whose bits 22:21 differ from `strap_i` leaves every register unchanged and issues no control strobe.
- R3: Select 000 writes payload bits 15:4 into the output code of the addressed channel only.
- R4: Select 010 writes the full payload into the gain of the addressed channel. Select 100 does the same for the offset.
- R5: Select 011 writes the payload into the gain of all channels. Select 101 writes it into the offset of all channels. The channel field is ignored for both.
- R6: Select 110 writes the payload into the clear code of the addressed channel.
- R7: The reserved select 001 changes no register and issues no control strobe.
- R8: Select 111 pulses `ctrl_we_o` for exactly one clock with `ctrl_wdata_o` equal to the payload. The pulse comes after chip select rises. No channel register changes.
- R9: With `pec_en_i` high, a frame must be exactly 32 clocks long. Its last 8 bits must equal a CRC-8 (polynomial 0x07, initial value 0, MSB first) over the first 24 bits. A 24-bit frame is then discarded.
- R10: A frame with a correct length but a wrong check byte is discarded and sets `pec_err_o`. This flag stays set until reset.
- R11: A read frame changes nothing. During the next frame, `miso_o` carries the selected register's 16 bits MSB first, each bit valid before its serial clock rising edge, followed by zeros. Select 000 returns the code followed by four zero bits. Selects 010/011 return the gain and 100/101 the offset of the channel in bits 17:16. Select 110 returns the clear code. Selects 001 and 111 return zero. Without an armed read, `miso_o` shifts out zeros.
- R12: After reset, codes are 0x000, gains 0xFFFF, offsets 0x8000, clear codes 0x0000, and `pec_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, sampled on `clk_i` |
| cs_ni | input | 1 | Active-low chip select; the rising edge ends a frame |
| mosi_i | input | 1 | Serial data in, MSB first |
| miso_o | output | 1 | Serial readback data |
| strap_i | input | 2 | Device address straps |
| pec_en_i | input | 1 | Enables the 8-bit check byte |
| data_o | output | NUM_CH*CODE_W | Output codes, channel c at bits c*CODE_W |
| gain_o | output | NUM_CH*16 | Gain registers |
| offs_o | output | NUM_CH*16 | Offset registers |
| clr_o | output | NUM_CH*16 | Clear-code registers |
| ctrl_we_o | output | 1 | Control register write strobe |
| ctrl_wdata_o | output | 16 | Control register write data |
| pec_err_o | output | 1 | Sticky check-byte mismatch flag |

## Verification
The assertions assume that `sclk_i` and `cs_ni` change only between `clk_i` edges and hold each level for at least two clocks. They also assume chip select stays high for several clocks between frames and during reset. Under these assumptions, a frame's result lands while chip select is still high, and registers cannot move inside a frame. The stimulus drives all pins on the falling system clock. Each serial clock phase lasts two system clocks, and chip select rests high for six clocks after every frame, so the stimulus never leaves that envelope.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned CMD_W = 24;
  localparam int unsigned PEC_W = 8;
  localparam int unsigned PAY_W = 16;
  localparam int unsigned CH_FW = 2;

  typedef enum logic [2:0] {
    SEL_DATA     = 3'b000,
    SEL_RSVD     = 3'b001,
    SEL_GAIN     = 3'b010,
    SEL_GAIN_ALL = 3'b011,
    SEL_OFFS     = 3'b100,
    SEL_OFFS_ALL = 3'b101,
    SEL_CLR      = 3'b110,
    SEL_CTRL     = 3'b111
  } reg_sel_e;

  typedef struct packed {
    logic             rd;
    logic [1:0]       dev;
    reg_sel_e         sel;
    logic [CH_FW-1:0] ch;
    logic [PAY_W-1:0] pay;
  } cmd_t;

  typedef struct packed {
    logic             rd;
    logic [1:0]       dev;
    reg_sel_e         sel;
    logic [CH_FW-1:0] ch;
  } hdr_t;
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cmd_pkg::*;
#(
  parameter logic [PEC_W-1:0] PEC_POLY = 8'h07
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  input  logic pec_en_i,
  output logic sclk_rise_o,
  output logic cs_fall_o,
  output logic frame_ok_o,
  output logic pec_bad_o,
  output cmd_t frame_o
);
  localparam int unsigned FULL_W = CMD_W + PEC_W;
  localparam int unsigned CNT_W  = $clog2(FULL_W + 2);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FULL_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FULL_W + 1);

  logic              sclk_q, cs_q;
  logic [FULL_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PEC_W-1:0]  crc_q, crc_nx;
  logic              cs_rise, fb;

  assign sclk_rise_o = sclk_i & ~sclk_q & ~cs_ni;
  assign cs_fall_o   = ~cs_ni & cs_q;
  assign cs_rise     = cs_ni & ~cs_q;
  assign fb          = crc_q[PEC_W-1] ^ mosi_i;
  assign crc_nx      = {crc_q[PEC_W-2:0], 1'b0} ^ (fb ? PEC_POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      sr_q       <= '0;
      cnt_q      <= '0;
      crc_q      <= '0;
      frame_ok_o <= 1'b0;
      pec_bad_o  <= 1'b0;
      frame_o    <= '0;
    end else begin
      sclk_q     <= sclk_i;
      cs_q       <= cs_ni;
      frame_ok_o <= 1'b0;
      pec_bad_o  <= 1'b0;
      if (cs_ni) begin
        cnt_q <= '0;
        crc_q <= '0;
      end else if (sclk_rise_o) begin
        sr_q <= {sr_q[FULL_W-2:0], mosi_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CNT_CMD) crc_q <= crc_nx;
      end
      if (cs_rise) begin
        if (pec_en_i) begin
          if (cnt_q == CNT_FULL) begin
            frame_o <= cmd_t'(sr_q[FULL_W-1:PEC_W]);
            if (sr_q[PEC_W-1:0] == crc_q) frame_ok_o <= 1'b1;
            else                          pec_bad_o  <= 1'b1;
          end
        end else if (cnt_q == CNT_CMD) begin
          frame_o    <= cmd_t'(sr_q[CMD_W-1:0]);
          frame_ok_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              frame_ok_i,
  input  hdr_t              hdr_i,
  input  logic [1:0]        strap_i,
  output logic [NUM_CH-1:0] data_we_o,
  output logic [NUM_CH-1:0] gain_we_o,
  output logic [NUM_CH-1:0] offs_we_o,
  output logic [NUM_CH-1:0] clr_we_o,
  output logic              ctrl_we_o,
  output logic              rd_req_o
);
  logic act, wr;
  assign act       = frame_ok_i & (hdr_i.dev == strap_i);
  assign wr        = act & ~hdr_i.rd;
  assign rd_req_o  = act & hdr_i.rd;
  assign ctrl_we_o = wr & (hdr_i.sel == SEL_CTRL);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (hdr_i.ch == CH_FW'(c));
    assign data_we_o[c] = wr & hit & (hdr_i.sel == SEL_DATA);
    assign gain_we_o[c] = wr & ((hit & (hdr_i.sel == SEL_GAIN)) | (hdr_i.sel == SEL_GAIN_ALL));
    assign offs_we_o[c] = wr & ((hit & (hdr_i.sel == SEL_OFFS)) | (hdr_i.sel == SEL_OFFS_ALL));
    assign clr_we_o[c]  = wr & hit & (hdr_i.sel == SEL_CLR);
  end
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned      NUM_CH   = 4,
  parameter int unsigned      CODE_W   = 12,
  parameter logic [PAY_W-1:0] GAIN_RST = 16'hFFFF,
  parameter logic [PAY_W-1:0] OFFS_RST = 16'h8000,
  parameter logic [PAY_W-1:0] CLR_RST  = 16'h0000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          data_we_i,
  input  logic [NUM_CH-1:0]          gain_we_i,
  input  logic [NUM_CH-1:0]          offs_we_i,
  input  logic [NUM_CH-1:0]          clr_we_i,
  input  logic [CODE_W-1:0]          code_i,
  input  logic [PAY_W-1:0]           pay_i,
  output logic [NUM_CH*CODE_W-1:0]   data_o,
  output logic [NUM_CH*PAY_W-1:0]    gain_o,
  output logic [NUM_CH*PAY_W-1:0]    offs_o,
  output logic [NUM_CH*PAY_W-1:0]    clr_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[c*CODE_W +: CODE_W] <= '0;
        gain_o[c*PAY_W +: PAY_W]   <= GAIN_RST;
        offs_o[c*PAY_W +: PAY_W]   <= OFFS_RST;
        clr_o[c*PAY_W +: PAY_W]    <= CLR_RST;
      end else begin
        if (data_we_i[c]) data_o[c*CODE_W +: CODE_W] <= code_i;
        if (gain_we_i[c]) gain_o[c*PAY_W +: PAY_W]   <= pay_i;
        if (offs_we_i[c]) offs_o[c*PAY_W +: PAY_W]   <= pay_i;
        if (clr_we_i[c])  clr_o[c*PAY_W +: PAY_W]    <= pay_i;
      end
    end
  end
endmodule

// File: rtl/spi_rd_shift.sv
module spi_rd_shift #(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             sclk_rise_i,
  input  logic             load_en_i,
  input  logic [REG_W-1:0] load_val_i,
  output logic             miso_o
);
  logic [REG_W-1:0] sr_q;
  assign miso_o = sr_q[REG_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sr_q <= '0;
    else if (cs_fall_i)   sr_q <= load_en_i ? load_val_i : '0;
    else if (sclk_rise_i) sr_q <= {sr_q[REG_W-2:0], 1'b0};
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int unsigned      NUM_CH   = 4,
  parameter int unsigned      CODE_W   = 12,
  parameter logic [PAY_W-1:0] GAIN_RST = 16'hFFFF,
  parameter logic [PAY_W-1:0] OFFS_RST = 16'h8000,
  parameter logic [PAY_W-1:0] CLR_RST  = 16'h0000,
  parameter logic [PEC_W-1:0] PEC_POLY = 8'h07
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     cs_ni,
  input  logic                     mosi_i,
  output logic                     miso_o,
  input  logic [1:0]               strap_i,
  input  logic                     pec_en_i,
  output logic [NUM_CH*CODE_W-1:0] data_o,
  output logic [NUM_CH*PAY_W-1:0]  gain_o,
  output logic [NUM_CH*PAY_W-1:0]  offs_o,
  output logic [NUM_CH*PAY_W-1:0]  clr_o,
  output logic                     ctrl_we_o,
  output logic [PAY_W-1:0]         ctrl_wdata_o,
  output logic                     pec_err_o
);
  localparam int unsigned PAD_W = PAY_W - CODE_W;

  logic              sclk_rise, cs_fall, frame_ok, pec_bad, rd_req;
  cmd_t              frame;
  hdr_t              hdr;
  logic [NUM_CH-1:0] data_we, gain_we, offs_we, clr_we;
  logic              rd_pend_q;
  reg_sel_e          rd_sel_q;
  logic [CH_FW-1:0]  rd_ch_q;
  logic [PAY_W-1:0]  rb_val;

  assign hdr          = '{rd: frame.rd, dev: frame.dev, sel: frame.sel, ch: frame.ch};
  assign ctrl_wdata_o = frame.pay;

  spi_frame_rx #(.PEC_POLY(PEC_POLY)) u_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i, .pec_en_i,
    .sclk_rise_o(sclk_rise), .cs_fall_o(cs_fall),
    .frame_ok_o(frame_ok), .pec_bad_o(pec_bad), .frame_o(frame)
  );

  spi_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .frame_ok_i(frame_ok), .hdr_i(hdr), .strap_i,
    .data_we_o(data_we), .gain_we_o(gain_we), .offs_we_o(offs_we),
    .clr_we_o(clr_we), .ctrl_we_o, .rd_req_o(rd_req)
  );

  spi_chan_regs #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W),
    .GAIN_RST(GAIN_RST), .OFFS_RST(OFFS_RST), .CLR_RST(CLR_RST)
  ) u_regs (
    .clk_i, .rst_ni,
    .data_we_i(data_we), .gain_we_i(gain_we), .offs_we_i(offs_we), .clr_we_i(clr_we),
    .code_i(frame.pay[PAY_W-1 -: CODE_W]), .pay_i(frame.pay),
    .data_o, .gain_o, .offs_o, .clr_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pec_err_o <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_sel_q  <= SEL_RSVD;
      rd_ch_q   <= '0;
    end else begin
      if (pec_bad) pec_err_o <= 1'b1;
      if (cs_fall) rd_pend_q <= 1'b0;
      else if (rd_req) begin
        rd_pend_q <= 1'b1;
        rd_sel_q  <= frame.sel;
        rd_ch_q   <= frame.ch;
      end
    end
  end

  always_comb begin
    rb_val = '0;
    if (int'(rd_ch_q) < NUM_CH) begin
      unique case (rd_sel_q)
        SEL_DATA:               rb_val = {data_o[rd_ch_q*CODE_W +: CODE_W], {PAD_W{1'b0}}};
        SEL_GAIN, SEL_GAIN_ALL: rb_val = gain_o[rd_ch_q*PAY_W +: PAY_W];
        SEL_OFFS, SEL_OFFS_ALL: rb_val = offs_o[rd_ch_q*PAY_W +: PAY_W];
        SEL_CLR:                rb_val = clr_o[rd_ch_q*PAY_W +: PAY_W];
        default:                rb_val = '0;
      endcase
    end
  end

  spi_rd_shift #(.REG_W(PAY_W)) u_rd (
    .clk_i, .rst_ni, .cs_fall_i(cs_fall), .sclk_rise_i(sclk_rise),
    .load_en_i(rd_pend_q), .load_val_i(rb_val), .miso_o
  );
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CODE_W = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cs_ni,
  input logic                     ctrl_we_o,
  input logic                     pec_err_o,
  input logic [NUM_CH*CODE_W-1:0] data_o,
  input logic [NUM_CH*16-1:0]     gain_o,
  input logic [NUM_CH*16-1:0]     offs_o,
  input logic [NUM_CH*16-1:0]     clr_o
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  a_r8_ctrl_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |=> !ctrl_we_o);

  a_r8_ctrl_after_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |-> cs_ni);

  a_r10_pec_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pec_err_o |=> pec_err_o);

  // R1: registers only move once a frame has closed
  a_r1_hold_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && !cs_ni && !$past(cs_ni) && !$past(cs_ni, 2))
      |-> ($stable(data_o) && $stable(gain_o) && $stable(offs_o) && $stable(clr_o)));

  a_r8_no_ctrl_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && !cs_ni && !$past(cs_ni)) |-> !ctrl_we_o);
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .ctrl_we_o(ctrl_we_o),
  .pec_err_o(pec_err_o), .data_o(data_o), .gain_o(gain_o), .offs_o(offs_o), .clr_o(clr_o)
);

// File: tb/spi_cmd_decoder_test.sv
`timescale 1ns/1ps
module spi_cmd_decoder_test;
  localparam int NCH = 4;
  localparam int CW  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, pec_en = 1'b0;
  logic [1:0] strap = 2'b10;
  logic miso, ctrl_we, pec_err;
  logic [15:0] ctrl_wdata;
  logic [NCH*CW-1:0] data;
  logic [NCH*16-1:0] gain, offs, clr;

  always #2.5 clk = ~clk;

  spi_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .strap_i(strap), .pec_en_i(pec_en),
    .data_o(data), .gain_o(gain), .offs_o(offs), .clr_o(clr),
    .ctrl_we_o(ctrl_we), .ctrl_wdata_o(ctrl_wdata), .pec_err_o(pec_err)
  );

  int n_chk = 0, n_fail = 0;
  int ctrl_cnt = 0;
  logic [15:0] ctrl_last = '0;
  always @(negedge clk) if (ctrl_we) begin ctrl_cnt++; ctrl_last = ctrl_wdata; end

  // expected state
  logic [CW-1:0] m_data [NCH];
  logic [15:0]   m_gain [NCH], m_offs [NCH], m_clr [NCH];
  logic          m_err, m_pend;
  logic [2:0]    m_rsel;
  logic [1:0]    m_rch;
  int            m_ctrl_cnt;
  logic [15:0]   m_ctrl_val;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [23:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [23:0] mk(input logic rd, input logic [1:0] dev, input logic [2:0] sel,
                                     input logic [1:0] ch, input logic [15:0] pay);
    return {rd, dev, sel, ch, pay};
  endfunction

  function automatic logic [15:0] rb_exp();
    case (m_rsel)
      3'd0:       return {m_data[m_rch], 4'h0};
      3'd2, 3'd3: return m_gain[m_rch];
      3'd4, 3'd5: return m_offs[m_rch];
      3'd6:       return m_clr[m_rch];
      default:    return 16'h0;
    endcase
  endfunction

  task automatic model(input logic [31:0] w, input int n);
    logic [23:0] c;
    if (n != (pec_en ? 32 : 24)) return;
    if (pec_en) begin
      c = w[31:8];
      if (crc8(c) != w[7:0]) begin m_err = 1'b1; return; end
    end else c = w[23:0];
    if (c[22:21] != strap) return;
    if (c[23]) begin m_pend = 1'b1; m_rsel = c[20:18]; m_rch = c[17:16]; return; end
    case (c[20:18])
      3'd0: m_data[c[17:16]] = c[15:4];
      3'd2: m_gain[c[17:16]] = c[15:0];
      3'd3: for (int k = 0; k < NCH; k++) m_gain[k] = c[15:0];
      3'd4: m_offs[c[17:16]] = c[15:0];
      3'd5: for (int k = 0; k < NCH; k++) m_offs[k] = c[15:0];
      3'd6: m_clr[c[17:16]] = c[15:0];
      3'd7: begin m_ctrl_cnt++; m_ctrl_val = c[15:0]; end
      default: ;
    endcase
  endtask

  // sends the low n bits of w MSB first; rx collects miso, left aligned
  task automatic send(input logic [31:0] w, input int n, output logic [31:0] rx, output logic [31:0] rx_exp);
    rx = '0;
    rx_exp = m_pend ? {rb_exp(), 16'h0} : 32'h0;
    m_pend = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = w[i];
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      if (n - 1 - i < 32) rx[31 - (n - 1 - i)] = miso;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    model(w, n);
  endtask

  task automatic cmp_all(input string req);
    for (int k = 0; k < NCH; k++) begin
      chk({req, " code"}, 32'(data[k*CW +: CW]), 32'(m_data[k]));
      chk({req, " gain"}, 32'(gain[k*16 +: 16]), 32'(m_gain[k]));
      chk({req, " offs"}, 32'(offs[k*16 +: 16]), 32'(m_offs[k]));
      chk({req, " clr"},  32'(clr[k*16 +: 16]),  32'(m_clr[k]));
    end
    chk({req, " pec_err"}, 32'(pec_err), 32'(m_err));
    chk({req, " ctrl count"}, 32'(ctrl_cnt), 32'(m_ctrl_cnt));
    chk({req, " ctrl data"}, 32'(ctrl_last), 32'(m_ctrl_val));
  endtask

  // {bit count, frame word}; strap fixed at 2'b10, checking off
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {6'd24, 32'h0041ABC0},  // R3 code ch1
    {6'd24, 32'h00431235},  // R3 code ch3, low nibble ignored
    {6'd24, 32'h00481234},  // R4 gain ch0
    {6'd24, 32'h004E5555},  // R5 gain all, ch field 2 ignored
    {6'd24, 32'h00520F0F},  // R4 offset ch2
    {6'd24, 32'h00557777},  // R5 offset all
    {6'd24, 32'h005BBEEF},  // R6 clear ch3
    {6'd24, 32'h0044FFFF},  // R7 reserved
    {6'd24, 32'h00209990},  // R2 wrong address
    {6'd23, 32'h00404440},  // R1 short frame
    {6'd25, 32'h00404440},  // R1 long frame
    {6'd24, 32'h005C2345}   // R8 control
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rx, rxe;
    logic [23:0] c;
    for (int k = 0; k < NCH; k++) begin
      m_data[k] = '0; m_gain[k] = 16'hFFFF; m_offs[k] = 16'h8000; m_clr[k] = '0;
    end
    m_err = 0; m_pend = 0; m_rsel = 3'd1; m_rch = 0; m_ctrl_cnt = 0; m_ctrl_val = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cmp_all("R12 reset");

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][31:0], int'(VEC[v][37:32]), rx, rxe);
      cmp_all($sformatf("R1-table vec%0d", v));
    end

    // R2: other strap value accepted
    strap = 2'b01;
    send({8'h0, mk(1'b0, 2'b01, 3'd0, 2'd0, 16'hFED0)}, 24, rx, rxe);
    cmp_all("R2 strap 01");
    strap = 2'b10;

    // R11: read code ch1, then fetch with a reserved frame
    send({8'h0, mk(1'b1, 2'b10, 3'd0, 2'd1, 16'h0)}, 24, rx, rxe);
    cmp_all("R11 read no change");
    send({8'h0, mk(1'b0, 2'b10, 3'd1, 2'd0, 16'h0)}, 24, rx, rxe);
    chk("R11 readback code", rx, rxe);
    chk("R11 readback code literal", rx, 32'hABC0_0000);
    send({8'h0, mk(1'b1, 2'b10, 3'd3, 2'd2, 16'h0)}, 24, rx, rxe);
    send({8'h0, mk(1'b0, 2'b10, 3'd1, 2'd0, 16'h0)}, 24, rx, rxe);
    chk("R11 readback gain", rx, 32'h5555_0000);
    send({8'h0, mk(1'b1, 2'b10, 3'd6, 2'd3, 16'h0)}, 24, rx, rxe);
    send({8'h0, mk(1'b0, 2'b10, 3'd1, 2'd0, 16'h0)}, 24, rx, rxe);
    chk("R11 readback clear", rx, 32'hBEEF_0000);
    send({8'h0, mk(1'b0, 2'b10, 3'd1, 2'd0, 16'h0)}, 24, rx, rxe);
    chk("R11 no pending read", rx, 32'h0);

    // R9: checking on
    pec_en = 1'b1;
    c = mk(1'b0, 2'b10, 3'd0, 2'd2, 16'h4560);
    send({c, crc8(c)}, 32, rx, rxe);
    cmp_all("R9 good check byte");
    chk("R9 code ch2", 32'(data[2*CW +: CW]), 32'h456);
    send({8'h0, mk(1'b0, 2'b10, 3'd0, 2'd2, 16'h1110)}, 24, rx, rxe);
    cmp_all("R9 short frame with checking");
    c = mk(1'b0, 2'b10, 3'd6, 2'd0, 16'h1357);
    send({c, crc8(c) ^ 8'h01}, 32, rx, rxe);
    cmp_all("R10 bad check byte");
    chk("R10 flag set", 32'(pec_err), 32'h1);
    c = mk(1'b0, 2'b10, 3'd7, 2'd0, 16'hA5A5);
    send({c, crc8(c)}, 32, rx, rxe);
    cmp_all("R10 flag sticky, R8 control");
    pec_en = 1'b0;

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NCH; k++) begin
      m_data[k] = '0; m_gain[k] = 16'hFFFF; m_offs[k] = 16'h8000; m_clr[k] = '0;
    end
    m_err = 0;
    repeat (2) @(negedge clk);
    cmp_all("R12 reset again");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule